// File: doc/BRIEF.md
# Base Address Register Hit Decoder

This block holds the base address registers (BARs) of one PCIe-style function and decides which of them, if any, claims an incoming request. Configuration software reaches the registers through a dword-addressed config port: it writes all ones, reads back a size mask, and then programs a base address. After that, a request port gives a 64-bit address and a flag that marks it as an I/O access or a memory access. In the same cycle the block answers with a hit flag and the index of the claiming slot. When nothing claims the request it answers with a miss, so the caller can report the request as unsupported.

The slot layout is fixed by parameters: whether each slot exists, whether it is I/O or memory, whether it is 64-bit, whether it is prefetchable, and its power-of-two size. A parameter picks a non-bridge header, which has six slots, or a bridge header, which has two. Slots are scanned from the lowest index upward. A 64-bit BAR uses the next slot as its upper address half, and that upper slot is never decoded as a BAR of its own. A slot that does not exist is hard-wired to zero.

Top module: `bar_hit_decoder`

## Requirements
- R1: After reset, every BAR reads back only its read-only type bits and the command dword (address 1) reads 0. With both enables clear, no request hits.
- R2: A slot that does not exist always reads 0, ignores writes and never hits. With the default parameters this is slot 4.
- R3: Writing all ones to a lower BAR slot reads back the size mask: address bits below the slot size read as zero, and the type bits are ORed into the value. The upper slot of a 64-bit pair reads back all 32 written bits.
- R4: The type bits are read-only. Bit 0 is 1 for I/O. Bits 2:1 are 10 for a 64-bit memory BAR and 00 otherwise. Bit 3 is 1 for a prefetchable memory BAR.
- R5: A 64-bit BAR compares request address bits 63:32 against its upper slot. BAR slot i sits at config dword 4+i.
- R6: A 32-bit memory BAR or an I/O BAR hits only when request address bits 63:32 are zero and the address bits at and above the slot size equal the programmed base.
- R7: Command dword bit 1 enables memory hits and bit 0 enables I/O hits. A clear bit blocks every hit of that kind.
- R8: A memory request never hits an I/O BAR, and an I/O request never hits a memory BAR.
- R9: When several BAR windows contain the address, the lowest slot index is reported.
- R10: With a valid request, exactly one of hit and miss is high. With no valid request, both are low. When there is no hit, the index reads 0.
- R11: With the bridge header type, only slots 0 and 1 exist. Dwords 6 to 9 read 0 and never produce a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | CFG_AW | Config dword address (1 = command, 4+i = BAR slot i) |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data, combinational from cfg_addr |
| req_valid | input | 1 | Request present |
| req_addr | input | 64 | Request address |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| hit | output | 1 | A BAR claims the request |
| hit_bar | output | 3 | Index of the claiming slot |
| miss | output | 1 | Valid request that no BAR claims |

## Verification
The bench probes each window exactly at its base, at its last byte and one byte past its end. A design that got the size mask wrong would either claim a neighbour's address or drop the last bytes of its own window. It presents addresses whose upper half does not match the 64-bit pair's upper slot, and addresses with a nonzero upper half aimed at a 32-bit window. If the high bits were ignored, these would show up as false hits. Two windows are placed so that one contains the other, so a reversed priority scan would report the wrong index. Toggling each command enable separately, crossing the request kinds, and writing to the absent slot and to the slots missing from the bridge variant would expose an enable, kind or presence check that is missing.

// File: rtl/bar_hit_decoder.sv
module bar_hit_decoder #(
  parameter int          HDR_TYPE  = 0,
  parameter logic [5:0]  IMPL_MASK = 6'b101111,
  parameter logic [5:0]  IO_MASK   = 6'b000010,
  parameter logic [5:0]  W64_MASK  = 6'b000100,
  parameter logic [5:0]  PREF_MASK = 6'b100100,
  parameter logic [47:0] SIZE_LOG2 = {8'd16, 8'd0, 8'd0, 8'd20, 8'd5, 8'd12},
  parameter int          CFG_AW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  input  logic              req_is_io,
  output logic              hit,
  output logic [2:0]        hit_bar,
  output logic              miss
);

  localparam int SLOTS     = (HDR_TYPE == 1) ? 2 : 6;
  localparam int CMD_ADDR  = 1;
  localparam int BAR_ADDR0 = 4;

  function automatic logic [5:0] calc_upper();
    logic [5:0] u;
    logic skip;
    u = '0;
    skip = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (skip) begin
        u[i] = 1'b1;
        skip = 1'b0;
      end else if (i + 1 < SLOTS && IMPL_MASK[i] && W64_MASK[i] && !IO_MASK[i]) begin
        skip = 1'b1;
      end
    end
    return u;
  endfunction

  function automatic logic [5:0] calc_active(logic [5:0] up);
    logic [5:0] a;
    for (int i = 0; i < 6; i++)
      a[i] = (i < SLOTS) && IMPL_MASK[i] && !up[i] &&
             !(W64_MASK[i] && !IO_MASK[i] && i + 1 >= SLOTS);
    return a;
  endfunction

  localparam logic [5:0] UPPER  = calc_upper();
  localparam logic [5:0] ACTIVE = calc_active(UPPER);
  localparam logic [5:0] WIDE   = ACTIVE & W64_MASK & ~IO_MASK;

  logic        io_en, mem_en;
  logic [31:0] bar_w  [6];
  logic [31:0] rd_bar [6];
  logic [5:0]  match;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {mem_en, io_en} <= 2'b00;
    else if (cfg_we && cfg_addr == CFG_AW'(CMD_ADDR)) {mem_en, io_en} <= cfg_wdata[1:0];

  for (genvar i = 0; i < 6; i++) begin : g_slot
    localparam int          SZ     = int'(SIZE_LOG2[8*i +: 8]);
    localparam logic [31:0] LOMASK = UPPER[i]  ? 32'hffff_ffff :
                                     ACTIVE[i] ? ~((32'd1 << SZ) - 32'd1) : 32'd0;
    localparam logic [31:0] TYPEB  = ACTIVE[i] ?
      {28'd0, PREF_MASK[i] & ~IO_MASK[i], WIDE[i], 1'b0, IO_MASK[i]} : 32'd0;
    logic [31:0] q;
    logic [31:0] hi;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q <= '0;
      else if (cfg_we && cfg_addr == CFG_AW'(BAR_ADDR0 + i)) q <= cfg_wdata & LOMASK;

    assign bar_w[i]  = q;
    assign rd_bar[i] = q | TYPEB;

    if (i < 5 && WIDE[i]) begin : g_wide
      assign hi = bar_w[i+1];
    end else begin : g_narrow
      assign hi = 32'd0;
    end

    assign match[i] = ACTIVE[i] && req_valid && (req_is_io == IO_MASK[i]) &&
                      (IO_MASK[i] ? io_en : mem_en) &&
                      (((req_addr ^ {hi, q}) & {32'hffff_ffff, LOMASK}) == 64'd0);

    if (!ACTIVE[i] && !UPPER[i]) begin : g_absent
      assert_absent_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == CFG_AW'(BAR_ADDR0 + i)) |-> (cfg_rdata == 32'd0));
      assert_absent_never_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_bar != 3'(i)));
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CFG_AW'(CMD_ADDR)) cfg_rdata = {30'd0, mem_en, io_en};
    for (int i = 0; i < 6; i++)
      if (cfg_addr == CFG_AW'(BAR_ADDR0 + i)) cfg_rdata = rd_bar[i];
  end

  always_comb begin
    hit_bar = '0;
    for (int i = 5; i >= 0; i--)
      if (match[i]) hit_bar = 3'(i);
  end

  assign hit  = |match;
  assign miss = req_valid & ~hit;

  assert_mem_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !req_is_io) |-> mem_en);
  assert_io_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && req_is_io) |-> io_en);
  assert_kind_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (IO_MASK[hit_bar] == req_is_io));
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (hit != miss));
  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!hit && !miss));
  assert_slot_in_header_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(hit_bar) < SLOTS));

endmodule

// File: tb/bar_hit_decoder_test.sv
module bar_hit_decoder_test;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [5:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        req_valid = 0, req_is_io = 0;
  logic [63:0] req_addr = 0;
  logic [31:0] rd0, rd1;
  logic        hit0, miss0, hit1, miss1;
  logic [2:0]  idx0, idx1;

  int nchk = 0, nfail = 0;
  logic [31:0] sh [6];
  logic        sh_io = 0, sh_mem = 0;

  always #10 clk = ~clk;

  bar_hit_decoder uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd0), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_io(req_is_io), .hit(hit0), .hit_bar(idx0), .miss(miss0));

  bar_hit_decoder #(.HDR_TYPE(1)) uut_br (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(rd1), .req_valid(req_valid),
    .req_addr(req_addr), .req_is_io(req_is_io), .hit(hit1), .hit_bar(idx1), .miss(miss1));

  function automatic logic [31:0] msk(int i);
    case (i)
      0: return ~32'h0000_0fff;
      1: return ~32'h0000_001f;
      2: return ~32'h000f_ffff;
      5: return ~32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(int a, int ns);
    if (a == 1) return {30'd0, sh_mem, sh_io};
    if (a < 4 || a >= 4 + ns) return 32'd0;
    case (a - 4)
      0: return sh[0] & msk(0);
      1: return (sh[1] & msk(1)) | 32'h1;
      2: return (sh[2] & msk(2)) | 32'hC;
      3: return sh[3];
      5: return (sh[5] & msk(5)) | 32'h8;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic slot_hit(int i, logic [63:0] a, logic io);
    logic lo;
    lo = ((a[31:0] ^ sh[i]) & msk(i)) == 32'd0;
    case (i)
      0: return !io && sh_mem && a[63:32] == 0 && lo;
      1: return io && sh_io && a[63:32] == 0 && lo;
      2: return !io && sh_mem && a[63:32] == sh[3] && lo;
      5: return !io && sh_mem && a[63:32] == 0 && lo;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] exp_dec(logic [63:0] a, logic io, logic v, int ns);
    if (!v) return 4'd0;
    for (int i = 0; i < ns; i++)
      if (slot_hit(i, a, io)) return {1'b1, 3'(i)};
    return 4'd0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(int a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a == 1) {sh_mem, sh_io} = d[1:0];
    if (a >= 4 && a <= 9) sh[a-4] = d;
  endtask

  task automatic read_chk(int a, string tag);
    @(negedge clk);
    cfg_addr = 6'(a);
    #2;
    chk(tag, 64'(rd0), 64'(exp_read(a, 6)));
    chk({tag, "/R11"}, 64'(rd1), 64'(exp_read(a, 2)));
  endtask

  task automatic req_chk(logic [63:0] a, logic io, logic v, string tag);
    logic [3:0] e0, e1;
    @(negedge clk);
    req_addr = a; req_is_io = io; req_valid = v;
    #2;
    e0 = exp_dec(a, io, v, 6);
    e1 = exp_dec(a, io, v, 2);
    chk(tag, {59'd0, hit0, idx0, miss0}, {59'd0, e0, v & ~e0[3]});
    chk({tag, "/R11"}, {59'd0, hit1, idx1, miss1}, {59'd0, e1, v & ~e1[3]});
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [63:0] a;
    for (int i = 0; i < 6; i++) sh[i] = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int a2 = 0; a2 < 11; a2++) read_chk(a2, "R1 reset readback");
    req_chk(64'h0, 0, 1, "R1 no hit after reset");
    req_chk(64'h0, 1, 1, "R1 no io hit after reset");

    for (int a2 = 4; a2 < 10; a2++) cfg_write(a2, 32'hffff_ffff);
    for (int a2 = 4; a2 < 10; a2++) read_chk(a2, "R3 sizing mask");
    read_chk(8, "R2 absent slot after write");
    for (int a2 = 4; a2 < 10; a2++) cfg_write(a2, 32'h0);
    for (int a2 = 4; a2 < 10; a2++) read_chk(a2, "R4 type bits only");

    cfg_write(4, 32'h8000_1000);
    cfg_write(5, 32'h0000_1000);
    cfg_write(6, 32'h4010_0000);
    cfg_write(7, 32'h0000_0001);
    cfg_write(8, 32'h8000_0000);
    cfg_write(9, 32'h8000_0000);
    cfg_write(1, 32'h3);
    for (int a2 = 0; a2 < 11; a2++) read_chk(a2, "R5 programmed readback");

    req_chk(64'h0000_0000_8000_1000, 0, 1, "R9 nested window base picks slot0");
    req_chk(64'h0000_0000_8000_1fff, 0, 1, "R9 nested window end");
    req_chk(64'h0000_0000_8000_2000, 0, 1, "R6 slot5 outside slot0");
    req_chk(64'h0000_0000_8000_ffff, 0, 1, "R6 slot5 last byte");
    req_chk(64'h0000_0000_8001_0000, 0, 1, "R6 past slot5");
    req_chk(64'h0000_0001_8000_1000, 0, 1, "R6 high bits nonzero");
    req_chk(64'h0000_0001_4010_0000, 0, 1, "R5 wide base");
    req_chk(64'h0000_0001_401f_ffff, 0, 1, "R5 wide last byte");
    req_chk(64'h0000_0001_4020_0000, 0, 1, "R5 wide past end");
    req_chk(64'h0000_0000_4010_0000, 0, 1, "R5 wide wrong upper");
    req_chk(64'h0000_0002_4010_0000, 0, 1, "R5 wide other upper");
    req_chk(64'h0000_0000_0000_1000, 1, 1, "R6 io base");
    req_chk(64'h0000_0000_0000_101f, 1, 1, "R6 io last byte");
    req_chk(64'h0000_0000_0000_1020, 1, 1, "R6 io past end");
    req_chk(64'h0000_0000_0000_1000, 0, 1, "R8 mem request at io window");
    req_chk(64'h0000_0000_8000_1000, 1, 1, "R8 io request at mem window");
    req_chk(64'h0000_0000_8000_1000, 0, 0, "R10 idle request");
    cfg_write(1, 32'h1);
    req_chk(64'h0000_0000_8000_1000, 0, 1, "R7 mem disabled");
    req_chk(64'h0000_0000_0000_1004, 1, 1, "R7 io still enabled");
    cfg_write(1, 32'h2);
    req_chk(64'h0000_0000_0000_1004, 1, 1, "R7 io disabled");
    req_chk(64'h0000_0001_4010_0040, 0, 1, "R7 mem still enabled");
    cfg_write(1, 32'h3);
    cfg_write(8, 32'h8000_1000);
    read_chk(8, "R2 absent ignores write");
    req_chk(64'h0000_0000_8000_1000, 0, 1, "R2 absent never hits");

    for (int n = 0; n < 400; n++) begin
      int s;
      if ($urandom_range(0, 15) == 0) begin
        s = $urandom_range(1, 9);
        if (s < 4) s = 1;
        cfg_write(s, (s == 1) ? 32'($urandom_range(0, 3)) : $urandom());
        read_chk(s, "R3 random readback");
      end
      s = $urandom_range(0, 5);
      a = {$urandom(), $urandom()};
      case ($urandom_range(0, 3))
        0: a = {32'd0, (sh[s] & msk(s)) | (a[31:0] & ~msk(s))};
        1: a = {sh[3], (sh[2] & msk(2)) | (a[31:0] & ~msk(2))};
        2: a = {32'd0, a[31:0]};
        default: ;
      endcase
      req_chk(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) != 0),
              "R9 random decode");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule